// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Controller

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) handles register dependences and branches. It compares the source register numbers of the instruction in decode with the destination register, write enable and load marker of the younger stages. From that comparison it produces four kinds of output. The first is the operand mux selects that the execute stage will use in the next cycle. The others are a hold for the PC and the fetch/decode register, a bubble for the decode/execute register, and a flush for the fetch/decode register. Register results are written only in write-back.

Two elaboration parameters select the variant. `FWD_EN` chooses between two interlocks. With it set, the controller forwards results and stalls only on a load followed by an immediate use. With it clear, forwarding is off and a consumer waits until its producer has left write-back. `DELAY_SLOT` chooses how a taken branch, resolved in decode, is handled. With it clear, the controller uses predict-not-taken and squashes the one wrongly fetched instruction. With it set, the controller uses an architectural delay slot and never squashes.

Per cycle, the control action is one of three states. `ACT_RUN` means normal flow. `ACT_HOLD` means stall plus bubble. `ACT_SQUASH` means flush the fetch/decode register. HOLD is chosen over SQUASH, and SQUASH over RUN. Each operand select is a registered state with three values: `FS_RF` (00), `FS_WB` (01) and `FS_MEM` (10). The next select is computed in decode from the stage the producer occupies now. An execute-stage match moves the select to FS_MEM and a memory-stage match moves it to FS_WB. In every other case, and on any hold, the select returns to FS_RF.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both forward selects read 00 whatever the other inputs are.
- R2: With FWD_EN=1, if a decode source equals the nonzero destination of a writing, non-load execute-stage instruction, that operand's select is 10 in the next cycle and no hold is raised.
- R3: With FWD_EN=1, a match only with a writing memory-stage instruction gives select 01 in the next cycle. When the execute-stage and memory-stage instructions both match, the select is 10.
- R4: A source register number of 0 never raises a hold and never yields a select other than 00, in any mode.
- R5: With FWD_EN=1, a writing load in execute whose destination matches a decode source raises pc_hold and idex_bubble in the same cycle. Both selects are then 00 in the next cycle.
- R6: With FWD_EN=0, a decode source matching a writing instruction in execute, memory or write-back raises pc_hold and idex_bubble in the same cycle, and the selects stay 00. A back-to-back dependence therefore waits three cycles.
- R7: With FWD_EN=1, no hold is raised for writers in memory or write-back, for non-matching registers, or when write enable is clear. A match only in write-back gives select 00 (this mode expects a register file whose read returns a value written in the same cycle).
- R8: With DELAY_SLOT=0, ifid_flush is 1 in the same cycle exactly when br_resolved and br_taken are both 1 and no hold is raised. It is 0 for a not-taken or unresolved branch.
- R9: With DELAY_SLOT=1, ifid_flush is never raised, even for a taken branch.
- R10: When a hold and a taken branch occur in the same cycle, the hold wins and ifid_flush stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | First source register of the decode-stage instruction |
| id_rs2 | input | AW | Second source register of the decode-stage instruction |
| ex_rd | input | AW | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | AW | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | AW | Destination register of the write-back-stage instruction |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| br_resolved | input | 1 | A branch in decode has been evaluated this cycle |
| br_taken | input | 1 | The evaluated branch is taken |
| fwd_a | output | 2 | Execute operand A select: 00 register file, 01 write-back result, 10 memory-stage result |
| fwd_b | output | 2 | Execute operand B select, same encoding |
| pc_hold | output | 1 | Hold the PC and the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ifid_flush | output | 1 | Squash the fetch/decode register |

## Verification
The hold, bubble and flush outputs are combinational, so they are due in the same cycle as the inputs that cause them. The bench drives each input set at the falling edge and checks these outputs 2 ns later. The forward selects go through one register, so the selects that follow from an input set are due after the next rising edge. The bench carries its expected selects across that edge and checks them in the following step, under the requirement tag of the step that caused them. Four instances, one per mode pair, see the same stimulus and are checked against a cycle-level model.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        FS_RF  = 2'b00,
        FS_WB  = 2'b01,
        FS_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ACT_RUN    = 2'd0,
        ACT_HOLD   = 2'd1,
        ACT_SQUASH = 2'd2
    } ctl_act_e;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Register 0 is hard-wired; it never produces a dependence.
    always_comb begin
        hit = wen && (dst != ZERO_REG) && (src == dst);
    end
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock #(
    parameter bit FWD_EN = 1'b1,
    parameter int NSRC   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hit_ex,
    input  logic [NSRC-1:0] hit_mem,
    input  logic [NSRC-1:0] hit_wb,
    input  logic            ex_load,
    output logic            stall
);
    always_comb begin
        if (FWD_EN) begin
            // Only load data arrives too late for the forward paths.
            stall = ex_load && (|hit_ex);
        end else begin
            // Wait until the producer has left write-back.
            stall = (|hit_ex) || (|hit_mem) || (|hit_wb);
        end
    end

    if (FWD_EN) begin : g_fwd_chk
        AST_LOAD_ONLY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            !ex_load |-> !stall); // R7
    end else begin : g_nofwd_chk
        AST_WB_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            (|hit_wb) |-> stall); // R6
    end
endmodule

// File: rtl/hzd_fwd_reg.sv
module hzd_fwd_reg
    import hzd_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_ex,
    input  logic       hit_mem,
    input  logic       stall,
    output logic [1:0] sel
);
    fwd_sel_e sel_q;
    fwd_sel_e sel_d;

    // Next select: producer in EX now sits in MEM next cycle, MEM moves to WB.
    always_comb begin
        sel_d = FS_RF;
        if (FWD_EN && !stall) begin
            unique case ({hit_ex, hit_mem})
                2'b10, 2'b11: sel_d = FS_MEM;
                2'b01:        sel_d = FS_WB;
                default:      sel_d = FS_RF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= FS_RF;
        end else begin
            sel_q <= sel_d;
        end
    end

    always_comb begin
        sel = sel_q;
    end

    AST_BUBBLE_CLEARS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (sel_q == FS_RF)); // R5

    if (!FWD_EN) begin : g_nofwd_chk
        AST_NOFWD_RF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            sel_q == FS_RF); // R6
    end
endmodule

// File: rtl/hzd_action.sv
module hzd_action
    import hzd_pkg::*;
#(
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic br_resolved,
    input  logic br_taken,
    output logic pc_hold,
    output logic idex_bubble,
    output logic ifid_flush
);
    ctl_act_e act;

    // Priority: hold, then squash, then run.
    always_comb begin
        if (stall) begin
            act = ACT_HOLD;
        end else if (br_resolved && br_taken && !DELAY_SLOT) begin
            act = ACT_SQUASH;
        end else begin
            act = ACT_RUN;
        end
    end

    always_comb begin
        pc_hold     = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        unique case (act)
            ACT_HOLD: begin
                pc_hold     = 1'b1;
                idex_bubble = 1'b1;
            end
            ACT_SQUASH: ifid_flush = 1'b1;
            ACT_RUN:    ;
            default:    ;
        endcase
    end

    AST_FLUSH_TAKEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (br_resolved && br_taken)); // R8
    AST_HOLD_OVER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !ifid_flush); // R10

    if (DELAY_SLOT) begin : g_slot_chk
        AST_SLOT_NEVER_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
            !ifid_flush); // R9
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int AW         = 5,
    parameter bit FWD_EN     = 1'b1,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wr,
    input  logic          br_resolved,
    input  logic          br_taken,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          idex_bubble,
    output logic          ifid_flush
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic [AW-1:0]      src_reg [NUM_SRC];
    logic [NUM_SRC-1:0] hit_ex;
    logic [NUM_SRC-1:0] hit_mem;
    logic [NUM_SRC-1:0] hit_wb;
    logic [1:0]         sel_w   [NUM_SRC];
    logic               stall;

    assign src_reg[0] = id_rs1;
    assign src_reg[1] = id_rs2;

    hzd_interlock #(.FWD_EN(FWD_EN), .NSRC(NUM_SRC)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_ex  (hit_ex),
        .hit_mem (hit_mem),
        .hit_wb  (hit_wb),
        .ex_load (ex_load),
        .stall   (stall)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hzd_match #(.AW(AW)) u_m_ex (
            .src (src_reg[s]), .dst (ex_rd),  .wen (ex_wr),  .hit (hit_ex[s])
        );
        hzd_match #(.AW(AW)) u_m_mem (
            .src (src_reg[s]), .dst (mem_rd), .wen (mem_wr), .hit (hit_mem[s])
        );
        hzd_match #(.AW(AW)) u_m_wb (
            .src (src_reg[s]), .dst (wb_rd),  .wen (wb_wr),  .hit (hit_wb[s])
        );
        hzd_fwd_reg #(.FWD_EN(FWD_EN)) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_ex  (hit_ex[s]),
            .hit_mem (hit_mem[s]),
            .stall   (stall),
            .sel     (sel_w[s])
        );
    end

    assign fwd_a = sel_w[0];
    assign fwd_b = sel_w[1];

    hzd_action #(.DELAY_SLOT(DELAY_SLOT)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .br_resolved (br_resolved),
        .br_taken    (br_taken),
        .pc_hold     (pc_hold),
        .idex_bubble (idex_bubble),
        .ifid_flush  (ifid_flush)
    );

    AST_MEM_FWD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == FS_MEM) |->
        $past(ex_wr && !ex_load && (ex_rd == id_rs1) && (id_rs1 != ZERO_REG))); // R2
    AST_ZERO_SRC_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_rs1 == ZERO_REG) && (id_rs2 == ZERO_REG)) |-> !pc_hold); // R4
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;
    localparam int AW = 5;
    localparam bit MFWD [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    localparam bit MDS  [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic          ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0;
    logic          br_res = 1'b0, br_tk = 1'b0;

    logic [1:0] fa [4];
    logic [1:0] fb [4];
    logic       ph [4];
    logic       bub [4];
    logic       fl [4];

    pipe_hazard_ctrl #(.AW(AW), .FWD_EN(1'b1), .DELAY_SLOT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_rd(wb_rd), .wb_wr(wb_wr), .br_resolved(br_res), .br_taken(br_tk),
        .fwd_a(fa[0]), .fwd_b(fb[0]), .pc_hold(ph[0]), .idex_bubble(bub[0]), .ifid_flush(fl[0]));
    pipe_hazard_ctrl #(.AW(AW), .FWD_EN(1'b1), .DELAY_SLOT(1'b1)) uut_f1d1 (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_rd(wb_rd), .wb_wr(wb_wr), .br_resolved(br_res), .br_taken(br_tk),
        .fwd_a(fa[1]), .fwd_b(fb[1]), .pc_hold(ph[1]), .idex_bubble(bub[1]), .ifid_flush(fl[1]));
    pipe_hazard_ctrl #(.AW(AW), .FWD_EN(1'b0), .DELAY_SLOT(1'b0)) uut_f0d0 (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_rd(wb_rd), .wb_wr(wb_wr), .br_resolved(br_res), .br_taken(br_tk),
        .fwd_a(fa[2]), .fwd_b(fb[2]), .pc_hold(ph[2]), .idex_bubble(bub[2]), .ifid_flush(fl[2]));
    pipe_hazard_ctrl #(.AW(AW), .FWD_EN(1'b0), .DELAY_SLOT(1'b1)) uut_f0d1 (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_rd(wb_rd), .wb_wr(wb_wr), .br_resolved(br_res), .br_taken(br_tk),
        .fwd_a(fa[3]), .fwd_b(fb[3]), .pc_hold(ph[3]), .idex_bubble(bub[3]), .ifid_flush(fl[3]));

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] exp_a [4];
    logic [1:0] exp_b [4];
    string prev_req = "R1";

    function automatic bit hit(input logic [AW-1:0] rs, input logic [AW-1:0] rd, input logic wr);
        return wr && (rd != '0) && (rs == rd);
    endfunction

    function automatic bit m_stall(input bit fw);
        bit ex_any;
        ex_any = hit(id_rs1, ex_rd, ex_wr) || hit(id_rs2, ex_rd, ex_wr);
        if (fw) return ex_load && ex_any;
        return ex_any || hit(id_rs1, mem_rd, mem_wr) || hit(id_rs2, mem_rd, mem_wr)
                      || hit(id_rs1, wb_rd, wb_wr) || hit(id_rs2, wb_rd, wb_wr);
    endfunction

    function automatic logic [1:0] m_sel(input bit fw, input bit st, input logic [AW-1:0] rs);
        if (!fw || st) return 2'b00;
        if (hit(rs, ex_rd, ex_wr)) return 2'b10;
        if (hit(rs, mem_rd, mem_wr)) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input string req, input string what, input int m,
                       input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s mode%0d actual=%0d expected=%0d", req, what, m, act, exp);
        end
    endtask

    // One pipeline cycle: drive at negedge, check comb outputs, then selects due from the previous step.
    task automatic step(input string req,
                        input logic [AW-1:0] r1, input logic [AW-1:0] r2,
                        input logic [AW-1:0] erd, input logic ew, input logic el,
                        input logic [AW-1:0] mrd, input logic mw,
                        input logic [AW-1:0] wrd, input logic ww,
                        input logic bres, input logic btk);
        logic [1:0] na [4];
        logic [1:0] nb [4];
        @(negedge clk);
        id_rs1 = r1; id_rs2 = r2; ex_rd = erd; ex_wr = ew; ex_load = el;
        mem_rd = mrd; mem_wr = mw; wb_rd = wrd; wb_wr = ww; br_res = bres; br_tk = btk;
        #2;
        for (int m = 0; m < 4; m++) begin
            bit st;
            st = m_stall(MFWD[m]);
            chk(req, "pc_hold", m, {1'b0, ph[m]}, {1'b0, st});
            chk(req, "idex_bubble", m, {1'b0, bub[m]}, {1'b0, st});
            chk(req, "ifid_flush", m, {1'b0, fl[m]}, {1'b0, !MDS[m] && bres && btk && !st});
            chk(prev_req, "fwd_a", m, fa[m], exp_a[m]);
            chk(prev_req, "fwd_b", m, fb[m], exp_b[m]);
            na[m] = m_sel(MFWD[m], st, r1);
            nb[m] = m_sel(MFWD[m], st, r2);
        end
        @(posedge clk);
        #1;
        for (int m = 0; m < 4; m++) begin
            exp_a[m] = na[m];
            exp_b[m] = nb[m];
        end
        prev_req = req;
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        id_rs1 = 5'd3; ex_rd = 5'd3; ex_wr = 1'b1; mem_rd = 5'd3; mem_wr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            chk("R1", "fwd_a in reset", m, fa[m], 2'b00);
            chk("R1", "fwd_b in reset", m, fb[m], 2'b00);
            exp_a[m] = 2'b00;
            exp_b[m] = 2'b00;
        end
        id_rs1 = '0; ex_rd = '0; ex_wr = 1'b0; mem_rd = '0; mem_wr = 1'b0;
        rst_n = 1'b1;
        prev_req = "R1";
    endtask

    task automatic t_alu_alu;
        step("R2", 3, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 7, 7, 1, 0, 0, 0, 0, 0, 0, 0);
        idle("R2");
    endtask

    task automatic t_mem_fwd;
        step("R3", 4, 0, 0, 0, 0, 4, 1, 0, 0, 0, 0);
        step("R3", 6, 6, 6, 1, 0, 6, 1, 0, 0, 0, 0);
        idle("R3");
    endtask

    task automatic t_load_use;
        step("R5", 5, 0, 5, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 5, 0, 0, 0, 0, 5, 1, 0, 0, 0, 0);
        step("R5", 0, 11, 11, 1, 1, 11, 1, 0, 0, 0, 0);
        idle("R5");
    endtask

    task automatic t_nofwd_chain;
        step("R6", 9, 0, 9, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 9, 0, 0, 0, 0, 9, 1, 0, 0, 0, 0);
        step("R6", 9, 0, 0, 0, 0, 0, 0, 9, 1, 0, 0);
        step("R6", 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle("R6");
    endtask

    task automatic t_zero_reg;
        step("R4", 0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0);
        step("R4", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        idle("R4");
    endtask

    task automatic t_indep;
        step("R7", 1, 2, 3, 1, 0, 4, 1, 5, 1, 0, 0);
        step("R7", 8, 8, 8, 0, 1, 8, 0, 8, 0, 0, 0);
        step("R7", 10, 0, 0, 0, 0, 0, 0, 10, 1, 0, 0);
        idle("R7");
    endtask

    task automatic t_branch;
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R9", 2, 3, 12, 1, 0, 13, 1, 0, 0, 1, 1);
        step("R10", 5, 0, 5, 1, 1, 0, 0, 0, 0, 1, 1);
        step("R10", 14, 0, 0, 0, 0, 14, 1, 0, 0, 1, 1);
        idle("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        idle("R1");
        t_alu_alu();
        t_mem_fwd();
        t_load_use();
        t_nofwd_chain();
        t_zero_reg();
        t_indep();
        t_branch();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule